// File: doc/BRIEF.md
# Subword Multiply-Accumulate Unit

This block is a two-stage pipelined multiply-accumulate engine for a signal-processing datapath. The data word is DATA_W bits wide (default 16). Each operand is seen as two halves of DATA_W/2 bits each. Both the whole word and each half are read as two's complement. One 2-bit mode select picks how a pair of operands is multiplied. It can give two separate half-word products, one full signed word product, or the real and imaginary terms of a complex product. In that last mode the upper half of each operand is the real part and the lower half is the imaginary part.

Every product comes from four signed half-width multipliers in the first stage. Full-word mode does not use a full-width multiplier. Instead it adds correction terms for the sign bits of the lower halves. All the terms, including the running accumulator, go through one carry-save reduction in the second stage. The accumulator is 2*DATA_W+GUARD_W bits wide (default 40). In the half-word and complex modes it splits into two independent lanes of equal width. Each lane has its own guard bits, and no carry passes between the lanes. A clear request that comes with an operand pair makes that product the new accumulator value.

Top module: `smac_unit`

## Requirements
- R1: After reset, acc_out is all zeros.
- R2: Operands sampled with in_valid high at a rising edge change acc_out at the next rising edge. A new operand pair is accepted on every cycle.
- R3: A cycle with in_valid low does not change the accumulator.
- R4: Half-word mode (mode_sel=0): the upper lane acc_out[ACC_W-1:ACC_W/2] accumulates AH*BH and the lower lane acc_out[ACC_W/2-1:0] accumulates AL*BL. Each lane wraps modulo 2^(ACC_W/2) and does not affect the other lane.
- R5: Full-word mode (mode_sel=1): acc_out accumulates the signed product A*B, sign-extended and wrapping modulo 2^ACC_W.
- R6: Complex mode (mode_sel=2): the upper lane accumulates AH*BH-AL*BL and the lower lane accumulates AL*BH+AH*BL, with lane wrapping as in R4.
- R7: mode_sel=3 behaves exactly like full-word mode.
- R8: When acc_clr is high together with in_valid, the accumulator (both lanes) becomes that cycle's product alone, with the same two-edge timing.
- R9: acc_clr has no effect while in_valid is low.
- R10: Half products are signed. The most negative half value times itself gives +2^(DATA_W-2) in every mode.
- R11: A zero operand B with acc_clr low leaves the accumulator unchanged in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand pair and controls are valid this cycle |
| mode_sel | input | 2 | 0 half-word, 1 full-word, 2 complex, 3 full-word |
| acc_clr | input | 1 | Restart accumulation with this cycle's product |
| op_a | input | DATA_W | Operand A, halves AH (upper) and AL (lower) |
| op_b | input | DATA_W | Operand B, halves BH (upper) and BL (lower) |
| acc_out | output | 2*DATA_W+GUARD_W | Accumulator; upper and lower lanes in split modes |

## Verification
Assertions check four things on every cycle. An idle cycle or a zero B operand leaves the accumulator stable. A clear paired with a zero A operand empties it. The lower lane holds still in half-word mode when its product is zero, whatever the upper lane does. Each registered half product carries the sign its operands predict. The exact arithmetic in each mode can only be shown by the bench's sweeps against an independent signed model. These cover wrapping at the lane boundaries, the lower-half sign corrections in full-word mode, and the most negative half values.

// File: rtl/smac_pkg.sv
package smac_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_WIDE  = 2'd1,
    MODE_CPLX  = 2'd2,
    MODE_WIDE2 = 2'd3
  } smac_mode_e;

  // Half-word and complex modes keep two independent accumulator lanes.
  function automatic logic lanes_split(input smac_mode_e m);
    return (m == MODE_SPLIT) || (m == MODE_CPLX);
  endfunction

endpackage

// File: rtl/smac_halfmul.sv
module smac_halfmul #(
  parameter int HW = 8
) (
  input  logic [HW-1:0]   x,
  input  logic [HW-1:0]   y,
  output logic [2*HW-1:0] p
);

  logic signed [2*HW-1:0] xs;
  logic signed [2*HW-1:0] ys;

  assign xs = {{HW{x[HW-1]}}, x};
  assign ys = {{HW{y[HW-1]}}, y};
  assign p  = xs * ys;

endmodule

// File: rtl/smac_mul_stage.sv
module smac_mul_stage #(
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_en,
  input  logic [1:0]          mode_in,
  input  logic                clr_in,
  input  logic [DW-1:0]       a,
  input  logic [DW-1:0]       b,
  output logic                vld_q,
  output logic [1:0]          mode_q,
  output logic                clr_q,
  output logic [DW-1:0]       a_q,
  output logic [DW-1:0]       b_q,
  output logic [3:0][DW-1:0]  pp_q
);

  localparam int HW = DW / 2;

  // pp index: bit1 picks the half of A, bit0 the half of B (1 = upper).
  logic [3:0][DW-1:0] pp_c;
  logic [3:0][DW-1:0] pp_d;
  logic [DW-1:0]      a_d;
  logic [DW-1:0]      b_d;
  logic [1:0]         mode_d;
  logic               clr_d;

  for (genvar g = 0; g < 4; g++) begin : g_sub
    logic [HW-1:0] xa;
    logic [HW-1:0] yb;
    assign xa = ((g / 2) == 1) ? a[DW-1:HW] : a[HW-1:0];
    assign yb = ((g % 2) == 1) ? b[DW-1:HW] : b[HW-1:0];
    smac_halfmul #(.HW(HW)) u_mul (
      .x (xa),
      .y (yb),
      .p (pp_c[g])
    );
  end

  always_comb begin
    pp_d   = in_en ? pp_c    : pp_q;
    a_d    = in_en ? a       : a_q;
    b_d    = in_en ? b       : b_q;
    mode_d = in_en ? mode_in : mode_q;
    clr_d  = in_en ? clr_in  : clr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      pp_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      vld_q  <= in_en;
      pp_q   <= pp_d;
      a_q    <= a_d;
      b_q    <= b_d;
      mode_q <= mode_d;
      clr_q  <= clr_d;
    end
  end

  // R10
  half_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_en && (a[DW-1:HW] != '0) && (b[DW-1:HW] != '0))
      |=> (pp_q[3][DW-1] == $past(a[DW-1] ^ b[DW-1])));

endmodule

// File: rtl/smac_csa_tree.sv
module smac_csa_tree #(
  parameter int WD = 40,
  parameter int LW = 20
) (
  input  logic [7:0][WD-1:0] rows,
  input  logic               split,
  output logic [WD-1:0]      total
);

  localparam logic [WD-1:0] LANE_BIT = WD'(1) << LW;

  // 3:2 compressor; the carry into the lane boundary is dropped when split.
  function automatic logic [2*WD-1:0] csa3(
    input logic [WD-1:0] x,
    input logic [WD-1:0] y,
    input logic [WD-1:0] z,
    input logic [WD-1:0] kill
  );
    logic [WD-1:0] s;
    logic [WD-1:0] m;
    logic [WD-1:0] c;
    s = x ^ y ^ z;
    m = (x & y) | (x & z) | (y & z);
    c = {m[WD-2:0], 1'b0} & ~kill;
    return {s, c};
  endfunction

  logic [WD-1:0]   kill;
  logic [WD-1:0]   s0, c0, s1, c1, s2, c2, s3, c3, s4, c4, s5, c5;
  logic [LW:0]     lo_sum;
  logic            lo_cout;
  logic [WD-LW-1:0] hi_sum;

  always_comb begin
    kill       = split ? LANE_BIT : '0;
    {s0, c0}   = csa3(rows[0], rows[1], rows[2], kill);
    {s1, c1}   = csa3(rows[3], rows[4], rows[5], kill);
    {s2, c2}   = csa3(s0, c0, s1, kill);
    {s3, c3}   = csa3(c1, rows[6], rows[7], kill);
    {s4, c4}   = csa3(s2, c2, s3, kill);
    {s5, c5}   = csa3(s4, c4, c3, kill);
    lo_sum     = {1'b0, s5[LW-1:0]} + {1'b0, c5[LW-1:0]};
    lo_cout    = split ? 1'b0 : lo_sum[LW];
    hi_sum     = s5[WD-1:LW] + c5[WD-1:LW] + {{(WD-LW-1){1'b0}}, lo_cout};
    total      = {hi_sum, lo_sum[LW-1:0]};
  end

endmodule

// File: rtl/smac_acc_stage.sv
module smac_acc_stage
  import smac_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vld,
  input  smac_mode_e         mode,
  input  logic               clr,
  input  logic [DW-1:0]      a_q,
  input  logic [DW-1:0]      b_q,
  input  logic [3:0][DW-1:0] pp,
  output logic [AW-1:0]      acc_q
);

  localparam int HW = DW / 2;
  localparam int LW = AW / 2;
  localparam logic [AW-1:0] TOP_CORR = AW'(0) - (AW'(1) << (2 * HW));

  function automatic logic [LW-1:0] lane_ext(input logic [DW-1:0] p);
    return {{(LW-DW){p[DW-1]}}, p};
  endfunction

  function automatic logic [AW-1:0] wide_ext(input logic [DW-1:0] p);
    return {{(AW-DW){p[DW-1]}}, p};
  endfunction

  logic [7:0][AW-1:0] rows;
  logic [AW-1:0]      base;
  logic [AW-1:0]      total;
  logic [AW-1:0]      acc_d;
  logic               split;

  always_comb begin
    base    = clr ? '0 : acc_q;
    split   = lanes_split(mode);
    rows    = '0;
    rows[0] = base;
    case (mode)
      MODE_SPLIT: begin
        rows[1] = {lane_ext(pp[3]), lane_ext(pp[0])};
      end
      MODE_CPLX: begin
        rows[1] = {lane_ext(pp[3]), lane_ext(pp[1])};
        rows[2] = {~lane_ext(pp[0]), lane_ext(pp[2])};
        rows[3] = {LW'(1), LW'(0)};
      end
      default: begin
        rows[1] = wide_ext(pp[3]) << (2 * HW);
        rows[2] = wide_ext(pp[2]) << HW;
        rows[3] = wide_ext(pp[1]) << HW;
        rows[4] = wide_ext(pp[0]);
        rows[5] = b_q[HW-1] ? (wide_ext(a_q) << HW) : '0;
        rows[6] = a_q[HW-1] ? (wide_ext(b_q) << HW) : '0;
        rows[7] = (a_q[HW-1] && b_q[HW-1]) ? TOP_CORR : '0;
      end
    endcase
  end

  smac_csa_tree #(.WD(AW), .LW(LW)) u_tree (
    .rows  (rows),
    .split (split),
    .total (total)
  );

  always_comb begin
    acc_d = vld ? total : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R4
  lane_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !clr && (mode == MODE_SPLIT) && (pp[0] == '0))
      |=> $stable(acc_q[LW-1:0]));

endmodule

// File: rtl/smac_unit.sv
module smac_unit
  import smac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [1:0]                    mode_sel,
  input  logic                          acc_clr,
  input  logic [DATA_W-1:0]             op_a,
  input  logic [DATA_W-1:0]             op_b,
  output logic [2*DATA_W+GUARD_W-1:0]   acc_out
);

  localparam int ACC_W = 2 * DATA_W + GUARD_W;

  logic [1:0]               rst_pipe;
  logic                     rst_q;
  logic                     vld_s1;
  logic [1:0]               mode_s1;
  logic                     clr_s1;
  logic [DATA_W-1:0]        a_s1;
  logic [DATA_W-1:0]        b_s1;
  logic [3:0][DATA_W-1:0]   pp_s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  smac_mul_stage #(.DW(DATA_W)) u_mul (
    .clk     (clk),
    .rst_n   (rst_q),
    .in_en   (in_valid),
    .mode_in (mode_sel),
    .clr_in  (acc_clr),
    .a       (op_a),
    .b       (op_b),
    .vld_q   (vld_s1),
    .mode_q  (mode_s1),
    .clr_q   (clr_s1),
    .a_q     (a_s1),
    .b_q     (b_s1),
    .pp_q    (pp_s1)
  );

  smac_acc_stage #(.DW(DATA_W), .AW(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_q),
    .vld   (vld_s1),
    .mode  (smac_mode_e'(mode_s1)),
    .clr   (clr_s1),
    .a_q   (a_s1),
    .b_q   (b_s1),
    .pp    (pp_s1),
    .acc_q (acc_out)
  );

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> ##1 $stable(acc_out));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && acc_clr && (op_a == '0)) |=> ##1 (acc_out == '0));

  // R11
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !acc_clr && (op_b == '0)) |=> ##1 $stable(acc_out));

endmodule

// File: tb/smac_unit_bench.sv
module smac_unit_bench;

  localparam int W  = 8;
  localparam int G  = 8;
  localparam int AW = 2 * W + G;
  localparam int LW = AW / 2;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    mode_sel;
  logic          acc_clr;
  logic [W-1:0]  op_a;
  logic [W-1:0]  op_b;
  logic [AW-1:0] acc_out;

  int            n_run;
  int            n_fail;
  bit            done;
  logic [AW-1:0] m_acc;
  logic [AW-1:0] e1;
  logic [AW-1:0] e2;
  string         t1;
  string         t2;

  smac_unit #(.DATA_W(W), .GUARD_W(G)) u_smac_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .mode_sel (mode_sel),
    .acc_clr  (acc_clr),
    .op_a     (op_a),
    .op_b     (op_b),
    .acc_out  (acc_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [AW-1:0] model(input logic [AW-1:0] acc, input logic v,
      input logic [1:0] md, input logic c, input logic [W-1:0] a, input logic [W-1:0] b);
    int ah, al, bh, bl, up, lo, full;
    logic [AW-1:0] base;
    logic [LW-1:0] u, l;
    if (!v) return acc;
    base = c ? '0 : acc;
    ah = $signed(a[7:4]); al = $signed(a[3:0]);
    bh = $signed(b[7:4]); bl = $signed(b[3:0]);
    if (md == 2'd0 || md == 2'd2) begin
      if (md == 2'd0) begin
        up = ah * bh;
        lo = al * bl;
      end else begin
        up = ah * bh - al * bl;
        lo = al * bh + ah * bl;
      end
      u = base[AW-1:LW] + up[LW-1:0];
      l = base[LW-1:0] + lo[LW-1:0];
      return {u, l};
    end
    full = $signed(a) * $signed(b);
    return base + full[AW-1:0];
  endfunction

  task automatic check_now(input string tag);
    n_run++;
    if (acc_out !== e2) begin
      n_fail++;
      $display("FAIL %s acc_out actual=%h expected=%h", tag, acc_out, e2);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] md, input logic c,
      input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    @(negedge clk);
    check_now(t2);
    in_valid = v; mode_sel = md; acc_clr = c; op_a = a; op_b = b;
    m_acc = model(m_acc, v, md, c, a, b);
    e2 = e1; t2 = t1;
    e1 = m_acc; t1 = tag;
  endtask

  task automatic sweep(input logic [1:0] md, input int sa, input int sb, input string tag);
    int cnt;
    cnt = 0;
    for (int a = 0; a < 256; a += sa) begin
      for (int b = 0; b < 256; b += sb) begin
        cnt++;
        if (cnt % 97 == 0) step(1'b0, md, cnt[0], 8'h00, 8'h00, "R3");
        if (cnt % 61 == 0) step(1'b1, md, 1'b1, a[7:0], b[7:0], "R8");
        else               step(1'b1, md, 1'b0, a[7:0], b[7:0], tag);
      end
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    m_acc = '0; e1 = '0; e2 = '0; t1 = "R1"; t2 = "R1";
    rst_n = 1'b0; in_valid = 1'b0; mode_sel = 2'd0; acc_clr = 1'b0;
    op_a = '0; op_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now("R1");
    rst_n = 1'b1;
    repeat (3) step(1'b0, 2'd0, 1'b0, 8'h00, 8'h00, "R1");

    // R2: single op then idles; the pipeline checks see no early update
    step(1'b1, 2'd1, 1'b1, 8'h03, 8'h05, "R2");
    step(1'b0, 2'd1, 1'b0, 8'h00, 8'h00, "R2");
    step(1'b1, 2'd1, 1'b0, 8'hF9, 8'h06, "R2");
    step(1'b1, 2'd1, 1'b0, 8'h2B, 8'hC4, "R2");
    step(1'b0, 2'd1, 1'b0, 8'h00, 8'h00, "R2");

    // R11: zero B in each mode
    step(1'b1, 2'd0, 1'b0, 8'h9A, 8'h00, "R11");
    step(1'b1, 2'd1, 1'b0, 8'h77, 8'h00, "R11");
    step(1'b1, 2'd2, 1'b0, 8'h5C, 8'h00, "R11");
    step(1'b1, 2'd3, 1'b0, 8'h81, 8'h00, "R11");

    // R10: most negative halves in every mode, then accumulate
    step(1'b1, 2'd0, 1'b1, 8'h88, 8'h88, "R10");
    for (int i = 0; i < 40; i++) step(1'b1, 2'd0, 1'b0, 8'h88, 8'h88, "R10");
    step(1'b1, 2'd2, 1'b1, 8'h88, 8'h88, "R10");
    step(1'b1, 2'd2, 1'b0, 8'h88, 8'h87, "R10");
    step(1'b1, 2'd1, 1'b1, 8'h80, 8'h80, "R10");
    step(1'b1, 2'd1, 1'b0, 8'h88, 8'h88, "R10");
    step(1'b1, 2'd3, 1'b0, 8'h88, 8'h08, "R10");

    // R9: clear without valid is ignored
    step(1'b0, 2'd1, 1'b1, 8'h11, 8'h22, "R9");
    step(1'b0, 2'd0, 1'b1, 8'h33, 8'h44, "R9");
    step(1'b0, 2'd2, 1'b1, 8'h55, 8'h66, "R9");
    step(1'b0, 2'd1, 1'b0, 8'h00, 8'h00, "R9");
    step(1'b0, 2'd1, 1'b0, 8'h00, 8'h00, "R9");

    sweep(2'd0, 1, 3, "R4");
    sweep(2'd2, 1, 3, "R6");
    sweep(2'd1, 1, 1, "R5");
    sweep(2'd3, 5, 7, "R7");

    repeat (3) step(1'b0, 2'd0, 1'b0, 8'h00, 8'h00, "R3");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule